// File: doc/BRIEF.md
# Parallel Memory Bus Cycle Decoder

This block is the bus front end of a parallel memory device. It receives the three active-low strobes (chip select, write strobe, output strobe) asynchronously. It samples them with a fast internal clock through a two-flop synchronizer. A per-strobe stability filter then rejects any level that does not persist for `GLITCH_CYCLES` clocks.

From the filtered strobes it classifies the bus as reading, writing, output-disabled or in standby. When the chip select and write strobe become jointly low, it captures the address, so the capture follows whichever of the two fell later. When that joint-low condition ends, it captures the data, so the capture follows whichever rose first. It then hands the address and data to the command logic as a one-cycle strobe. A write during which the output strobe goes low is discarded and recorded in a sticky error flag.

The block also drives the enable of the tri-state data pins and reports standby. It raises an automatic-standby flag after the selected bus has been idle for `IDLE_CYCLES` clocks.

Top module: `bus_op_decoder`

## Requirements
- R1: While the synchronous reset `rst` is high, `rd_en`, `wr_stb`, `standby`, `auto_standby` and `wr_err` are all 0.
- R2: `rd_en` is 1 only while the filtered strobes show chip select low, output strobe low and write strobe high; when the output strobe is high, `rd_en` is 0.
- R3: While the filtered chip select is high, `standby` is 1 and `rd_en` is 0, whatever the other two strobes do.
- R4: A pulse on any strobe that lasts fewer than `GLITCH_CYCLES` clocks changes no output; it neither starts nor ends a read or a write.
- R5: The write address is taken from `addr_in` at the moment the chip select and write strobe first become jointly low, that is, at the later of their two falling edges.
- R6: The write data is taken from `data_in` at the moment the chip select and write strobe stop being jointly low, that is, at the earlier of their two rising edges.
- R7: Each valid write gives exactly one `wr_stb` pulse one clock wide, and `wr_addr`/`wr_data` hold the captured values in that cycle.
- R8: If the output strobe is low at any time while a write is open, that write produces no `wr_stb`, and `wr_err` becomes 1 and stays 1 until reset.
- R9: `auto_standby` rises after chip select has stayed low with both other strobes high and no filtered strobe change for `IDLE_CYCLES` clocks. It falls on the next strobe activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip select strobe, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| oe_n | input | 1 | Output strobe, active low, asynchronous |
| addr_in | input | AW | Address bus |
| data_in | input | DW | Incoming data bus |
| wr_stb | output | 1 | One-cycle write pulse to the command logic |
| wr_addr | output | AW | Captured write address |
| wr_data | output | DW | Captured write data |
| rd_en | output | 1 | Output enable for the tri-state data pins |
| standby | output | 1 | Chip select is inactive |
| auto_standby | output | 1 | Selected but idle for the idle count |
| wr_err | output | 1 | Sticky flag for an aborted write |

## Verification
The assertions assume that reset is applied before any strobe activity. They also assume that the strobes and buses may change at any clock phase, since they are treated as asynchronous. Address capture follows the filtered strobes, which lag the pins by the synchronizer and filter delay. For that reason the stimulus holds the address stable for several clocks after the later falling strobe. It also holds the data stable for `GLITCH_CYCLES` plus a margin after the earlier rising strobe, and changes the buses only outside those windows. Glitch pulses are kept shorter than `GLITCH_CYCLES`, and every accepted level is held well past it.

// File: rtl/bus_op_decoder.sv
module bus_op_decoder #(
  parameter int AW            = 8,
  parameter int DW            = 8,
  parameter int GLITCH_CYCLES = 3,
  parameter int IDLE_CYCLES   = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rd_en,
  output logic          standby,
  output logic          auto_standby,
  output logic          wr_err
);
  localparam int CW = $clog2(GLITCH_CYCLES + 1);
  localparam int IW = $clog2(IDLE_CYCLES + 1);

  // index 0 = chip select, 1 = write strobe, 2 = output strobe (all active low)
  logic [2:0]    s1, s2, filt, filt_d;
  logic [CW-1:0] cnt [3];
  logic [IW-1:0] idle_cnt;
  logic          armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1     <= '1;
      s2     <= '1;
      filt   <= '1;
      filt_d <= '1;
      for (int i = 0; i < 3; i++) cnt[i] <= '0;
    end else begin
      s1     <= {oe_n, we_n, ce_n};
      s2     <= s1;
      filt_d <= filt;
      for (int i = 0; i < 3; i++) begin
        if (s2[i] == filt[i]) begin
          cnt[i] <= '0;
        end else if (cnt[i] == CW'(GLITCH_CYCLES - 1)) begin
          filt[i] <= s2[i];
          cnt[i]  <= '0;
        end else begin
          cnt[i] <= cnt[i] + 1'b1;
        end
      end
    end
  end

  wire ce      = ~filt[0];
  wire we      = ~filt[1];
  wire oe      = ~filt[2];
  wire joint   = ce & we;
  wire joint_d = ~filt_d[0] & ~filt_d[1];
  wire active  = |(filt ^ filt_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en   <= 1'b0;
      standby <= 1'b0;
    end else begin
      rd_en   <= ce & oe & ~we;
      standby <= ~ce;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      wr_err  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (joint && !joint_d) begin
        if (oe) begin
          wr_err <= 1'b1;
        end else begin
          armed   <= 1'b1;
          wr_addr <= addr_in;
        end
      end else if (armed && oe) begin
        armed  <= 1'b0;
        wr_err <= 1'b1;
      end else if (!joint && joint_d) begin
        if (armed) begin
          wr_stb  <= 1'b1;
          wr_data <= data_in;
          armed   <= 1'b0;
        end else begin
          wr_err <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !ce || we || oe || active) begin
      idle_cnt     <= '0;
      auto_standby <= 1'b0;
    end else if (idle_cnt == IW'(IDLE_CYCLES - 1)) begin
      auto_standby <= 1'b1;
    end else begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bus_op_decoder_chk.sv
module bus_op_decoder_chk (
  input logic clk,
  input logic rst,
  input logic ce_n,
  input logic wr_stb,
  input logic rd_en,
  input logic standby,
  input logic auto_standby,
  input logic wr_err
);
  // R7
  wr_stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  // R3
  rd_not_standby_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !standby);

  // R8
  wr_not_during_rd_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && rd_en));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    wr_err |=> wr_err);

  // R4
  ce_level_seen_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(standby) |-> !$past(ce_n, 3));

  // R9
  auto_selected_chk: assert property (@(posedge clk) disable iff (rst)
    auto_standby |-> (!standby && !rd_en));
endmodule

bind bus_op_decoder bus_op_decoder_chk u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .wr_stb(wr_stb), .rd_en(rd_en),
  .standby(standby), .auto_standby(auto_standby), .wr_err(wr_err)
);

// File: tb/sim_bus_op_decoder.sv
module sim_bus_op_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8, DW = 8, G = 3, IDLE = 16;
  localparam int HOLD = G + 6;

  logic clk = 0, rst = 1, ce_n = 1, we_n = 1, oe_n = 1;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] data_in = '0;
  logic wr_stb, rd_en, standby, auto_standby, wr_err;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int n_tests = 0, n_fail = 0, n_stb = 0;
  bit done = 0, prev_stb = 0;
  logic [AW+DW-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_op_decoder #(.AW(AW), .DW(DW), .GLITCH_CYCLES(G), .IDLE_CYCLES(IDLE)) u0 (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr_in(addr_in), .data_in(data_in), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .standby(standby),
    .auto_standby(auto_standby), .wr_err(wr_err));

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops expected writes as strobes appear
  always @(negedge clk) begin
    if (!rst && wr_stb) begin
      n_stb++;
      n_tests++;
      if (prev_stb) begin
        n_fail++;
        $display("FAIL R7: strobe width actual 2+ expected 1");
      end else if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R7: unexpected strobe actual %0h expected none", {wr_addr, wr_data});
      end else begin
        logic [AW+DW-1:0] e;
        e = exp_q.pop_front();
        if ({wr_addr, wr_data} != e) begin
          n_fail++;
          $display("FAIL R5/R6: addr,data actual %0h expected %0h", {wr_addr, wr_data}, e);
        end
      end
    end
    prev_stb = wr_stb;
  end

  task automatic write_we(logic [AW-1:0] a, logic [DW-1:0] d);
    addr_in = a; data_in = d; we_n = 0;
    tick(HOLD);
    exp_q.push_back({a, d});
    we_n = 1;
    tick(HOLD);
    addr_in = ~a; data_in = ~d;
  endtask

  task automatic hold_rd(string req, int exp);
    bit ok = 1;
    repeat (HOLD) begin
      tick(1);
      if (rd_en != exp[0]) ok = 0;
    end
    check(req, ok, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int s0;
    tick(3);
    check("R1 reset outputs", {rd_en, wr_stb, standby, auto_standby, wr_err}, 0);
    rst = 0;
    tick(HOLD);
    check("R3 standby idle", standby, 1);
    check("R3 rd_en idle", rd_en, 0);

    oe_n = 0; tick(HOLD);
    check("R3 standby with output strobe", {standby, rd_en}, 2'b10);

    ce_n = 0; tick(HOLD);
    check("R2 read enable", {rd_en, standby}, 2'b10);

    for (int w = 1; w < G; w++) begin
      ce_n = 1; tick(w); ce_n = 0;
      hold_rd("R4 chip select glitch", 1);
      we_n = 0; tick(w); we_n = 1;
      hold_rd("R4 write strobe glitch", 1);
    end
    check("R4 no write from glitch", {wr_err, 8'(n_stb)}, 0);

    oe_n = 1; tick(HOLD);
    check("R2 output strobe high", rd_en, 0);

    tick(IDLE / 2);
    check("R9 not yet idle", auto_standby, 0);
    tick(IDLE + HOLD);
    check("R9 auto standby", auto_standby, 1);
    oe_n = 0; tick(HOLD);
    check("R9 cleared by activity", auto_standby, 0);
    oe_n = 1; tick(HOLD);

    write_we(8'h3C, 8'hA5);
    write_we(8'hC3, 8'h5A);
    check("R7 two strobes", n_stb, 2);

    ce_n = 1; tick(HOLD);
    addr_in = 8'h11; we_n = 0; tick(HOLD);
    addr_in = 8'h22; tick(2);
    ce_n = 0; tick(HOLD);
    addr_in = 8'h33; data_in = 8'h44;
    exp_q.push_back({8'h22, 8'h44});
    we_n = 1; tick(HOLD);
    data_in = 8'h55; tick(HOLD);
    ce_n = 1; tick(HOLD);
    check("R5 R6 ordered write", n_stb, 3);

    we_n = 0; tick(HOLD);
    addr_in = 8'h66; data_in = 8'h77; ce_n = 0; tick(HOLD);
    exp_q.push_back({8'h66, 8'h77});
    ce_n = 1; tick(HOLD);
    addr_in = 8'h00; data_in = 8'h00; we_n = 1; tick(HOLD);
    check("R7 chip select controlled", n_stb, 4);

    s0 = n_stb;
    ce_n = 0; tick(HOLD);
    we_n = 0; tick(2);
    we_n = 1; tick(HOLD);
    check("R4 short write pulse", {wr_err, 8'(n_stb - s0)}, 0);

    addr_in = 8'h99; data_in = 8'h88; we_n = 0; tick(HOLD);
    oe_n = 0; tick(HOLD);
    oe_n = 1; tick(HOLD);
    we_n = 1; tick(HOLD);
    check("R8 aborted write flag", wr_err, 1);
    check("R8 no strobe", n_stb - s0, 0);

    write_we(8'hE1, 8'h1E);
    check("R8 sticky after good write", {wr_err, 8'(n_stb - s0)}, 9'h101);

    rst = 1; tick(2);
    check("R1 reset clears flag", {wr_err, standby}, 0);
    rst = 0; tick(HOLD);
    check("R7 queue drained", exp_q.size(), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule